// File: doc/BRIEF.md
# Pipelined Checkpoint Ring Controller

This block keeps a small ring of snapshot slots for an architectural register vector. One slot always holds the recovery point, a snapshot already known to be good. The other slots hold newer snapshots that are still waiting for the error checkers to clear them. Because several snapshots can wait at once, checking runs alongside normal execution. Execution only stops when every spare slot is occupied.

A snapshot is taken when the external take input is high, or when a programmable cycle timer expires. Each validate pulse promotes the oldest waiting snapshot to recovery point and releases the slot of the previous one. An error pulse presents the recovery-point contents on the restore bus with a one-cycle strobe. It also drops every waiting snapshot and restarts the timer. An error always takes precedence over validate and take in the same cycle.

Top module: `ckpt_ring_top`

## Requirements
- R1: After reset the restore strobe and stall are low and no snapshot is waiting. The recovery point holds an all-zero vector, so an error as the first event restores zeros.
- R2: A take request with at least one free slot copies `live_regs` at that clock edge into the slot after the newest waiting snapshot.
- R3: With a non-zero `tmr_period` P, a snapshot is taken P cycles after the most recent snapshot, restore or reset. A period of zero disables the timer.
- R4: At most SLOTS-1 (3 by default) snapshots wait at once. A take request or timer expiry while all are occupied raises `ckpt_stall` in the same cycle and captures nothing. The request is held, with stall high, until a validate frees a slot; the capture then happens at the next edge.
- R5: A validate pulse with at least one waiting snapshot makes the oldest one the new recovery point. A validate pulse with none waiting has no effect.
- R6: An error pulse raises `restore_valid` for exactly the next cycle, with the recovery-point vector on `restore_data`. After the error no snapshot is waiting, and any held take request is dropped.
- R7: When error and validate arrive in the same cycle, the validate is ignored, and the restore returns the recovery point from before that cycle.
- R8: The timer restarts from zero on every snapshot taken and on every restore.
- R9: A take request in the same cycle as an error captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_regs | input | REG_W | Live register vector to snapshot |
| ckpt_take | input | 1 | External request for a snapshot |
| tmr_period | input | TIMER_W | Periodic snapshot interval in cycles, 0 = off |
| validate_ok | input | 1 | Oldest waiting snapshot is confirmed error-free |
| err_detect | input | 1 | Error detected, roll back |
| restore_data | output | REG_W | Recovery-point vector shown during a restore |
| restore_valid | output | 1 | One-cycle restore strobe |
| ckpt_stall | output | 1 | A snapshot is wanted but every slot is occupied |

## Verification
A directed run fills the ring with distinct vectors and pushes a fourth request. It then checks that stall persists and that a validate lets the held request through. The restore shows which slot became the recovery point, which separates a capture into the wrong slot from a promotion of the wrong slot. Collisions of error with validate and with take show that error wins. The timer is swept over several periods, including zero and one, under a pseudo-random mix of take, validate and error. A reference model predicts stall every cycle and the restored vector on every error.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

    // actions decided by the ring controller for one cycle
    typedef struct packed {
        logic capture;   // write live vector into the tail slot
        logic promote;   // oldest waiting snapshot becomes recovery point
        logic restore;   // roll back to the recovery point
    } ckpt_act_t;

endpackage

// File: rtl/ckpt_period_timer.sv
module ckpt_period_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIMER_W-1:0] period,
    input  logic               restart,
    output logic               fire
);

    localparam logic [TIMER_W-1:0] SAT = {TIMER_W{1'b1}};

    logic [TIMER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        fire  = (period != '0) && (cnt_q >= period - 1'b1);
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (cnt_q != SAT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // once expired and not restarted, the trigger keeps asking
    AST_FIRE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !restart && $stable(period) |=> fire || $changed(period)); // R3

endmodule

// File: rtl/ckpt_slot_store.sv
module ckpt_slot_store #(
    parameter int REG_W = 32,
    parameter int SLOTS = 4,
    parameter int PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [REG_W-1:0] rd_data
);

    logic [REG_W-1:0] slot_d [SLOTS];
    logic [REG_W-1:0] slot_q [SLOTS];

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (wr_en) begin
            slot_d[wr_idx] = wr_data;
        end
        rd_data = slot_q[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    // the slot being read is never the slot being overwritten
    AST_NO_RP_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx != rd_idx); // R2

endmodule

// File: rtl/ckpt_ring_ctrl.sv
module ckpt_ring_ctrl
    import ckpt_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int PTR_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_req,
    input  logic             timer_fire,
    input  logic             validate,
    input  logic             error,
    output ckpt_act_t        act,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             stall
);

    localparam logic [CNT_W-1:0] MAX_WAIT = CNT_W'(SLOTS - 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(SLOTS - 1);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] waiting;
        logic             held_req;
    } ring_t;

    ring_t st_d, st_q;
    logic  want, full;

    function automatic logic [PTR_W-1:0] ring_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        want        = take_req || st_q.held_req || timer_fire;
        full        = (st_q.waiting == MAX_WAIT);
        stall       = want && full;
        act.restore = error;
        act.capture = !error && want && !full;
        act.promote = !error && validate && (st_q.waiting != '0);

        st_d = st_q;
        if (error) begin
            st_d.tail     = ring_inc(st_q.head);
            st_d.waiting  = '0;
            st_d.held_req = 1'b0;
        end else begin
            if (act.capture) begin
                st_d.tail    = ring_inc(st_q.tail);
                st_d.waiting = st_d.waiting + 1'b1;
            end
            if (act.promote) begin
                st_d.head    = ring_inc(st_q.head);
                st_d.waiting = st_d.waiting - 1'b1;
            end
            st_d.held_req = full && (take_req || st_q.held_req);
        end
        head = st_q.head;
        tail = st_q.tail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.head     <= '0;
            st_q.tail     <= PTR_W'(1);
            st_q.waiting  <= '0;
            st_q.held_req <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.waiting <= MAX_WAIT); // R4

    AST_STALL_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        stall && !validate && !error |=> stall); // R4

    AST_ERROR_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> st_q.waiting == '0 && !st_q.held_req); // R6

    AST_ERROR_BEATS_VALIDATE: assert property (@(posedge clk) disable iff (!rst_n)
        error && validate |=> head == $past(head)); // R7

    AST_PROMOTE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        validate && !error && st_q.waiting != '0 |=> head != $past(head)); // R5

    AST_IDLE_VALIDATE: assert property (@(posedge clk) disable iff (!rst_n)
        validate && st_q.waiting == '0 |=> head == $past(head)); // R5

endmodule

// File: rtl/ckpt_ring_top.sv
module ckpt_ring_top
    import ckpt_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int SLOTS   = 4,
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_W-1:0]   live_regs,
    input  logic               ckpt_take,
    input  logic [TIMER_W-1:0] tmr_period,
    input  logic               validate_ok,
    input  logic               err_detect,
    output logic [REG_W-1:0]   restore_data,
    output logic               restore_valid,
    output logic               ckpt_stall
);

    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] data;
    } rst_out_t;

    ckpt_act_t        act;
    logic [PTR_W-1:0] head, tail;
    logic [REG_W-1:0] rp_data;
    logic             fire;
    rst_out_t         out_d, out_q;

    ckpt_period_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (tmr_period),
        .restart (act.capture || act.restore),
        .fire    (fire)
    );

    ckpt_ring_ctrl #(.SLOTS(SLOTS), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_req   (ckpt_take),
        .timer_fire (fire),
        .validate   (validate_ok),
        .error      (err_detect),
        .act        (act),
        .head       (head),
        .tail       (tail),
        .stall      (ckpt_stall)
    );

    ckpt_slot_store #(.REG_W(REG_W), .SLOTS(SLOTS), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (act.capture),
        .wr_idx  (tail),
        .wr_data (live_regs),
        .rd_idx  (head),
        .rd_data (rp_data)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = act.restore;
        if (act.restore) begin
            out_d.data = rp_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign restore_valid = out_q.valid;
    assign restore_data  = out_q.data;

    AST_RESTORE_FOLLOWS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        err_detect |=> restore_valid); // R6

    AST_RESTORE_ONLY_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        !err_detect |=> !restore_valid); // R6

    AST_NO_CAPTURE_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        err_detect && ckpt_take |-> !act.capture); // R9

endmodule

// File: tb/sim_ckpt_ring_top.sv
module sim_ckpt_ring_top;

    localparam int REG_W = 32;
    localparam int SLOTS = 4;
    localparam int TW    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [REG_W-1:0] live_regs = '0;
    logic             ckpt_take = 1'b0;
    logic [TW-1:0]    tmr_period = '0;
    logic             validate_ok = 1'b0;
    logic             err_detect = 1'b0;
    logic [REG_W-1:0] restore_data;
    logic             restore_valid;
    logic             ckpt_stall;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    logic [REG_W-1:0] m_rp;
    logic [REG_W-1:0] m_q [SLOTS];
    int               m_cnt;
    int               m_timer;
    bit               m_held;

    always #4 clk = ~clk;

    ckpt_ring_top #(.REG_W(REG_W), .SLOTS(SLOTS), .TIMER_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .live_regs(live_regs), .ckpt_take(ckpt_take),
        .tmr_period(tmr_period), .validate_ok(validate_ok), .err_detect(err_detect),
        .restore_data(restore_data), .restore_valid(restore_valid), .ckpt_stall(ckpt_stall)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, check stall, model the rising edge,
    // then check the restore outputs at the next falling edge
    task automatic step(input bit req, input bit val, input bit err,
                        input logic [REG_W-1:0] live, input string tag);
        bit trig, full, cap, exp_rv;
        int old_cnt;
        logic [REG_W-1:0] exp_rd;
        ckpt_take   = req;
        validate_ok = val;
        err_detect  = err;
        live_regs   = live;
        #1;
        trig = req || m_held || (tmr_period != 0 && m_timer >= int'(tmr_period) - 1);
        full = (m_cnt == SLOTS - 1);
        chk(ckpt_stall == (trig && full), tag, "stall (R4)", REG_W'(ckpt_stall),
            REG_W'(trig && full));
        exp_rv = err;
        exp_rd = m_rp;
        if (err) begin
            m_cnt = 0; m_timer = 0; m_held = 0;
        end else begin
            old_cnt = m_cnt;
            cap = trig && !full;
            if (cap) begin
                m_q[m_cnt] = live;
                m_cnt++;
            end
            if (val && old_cnt > 0) begin
                m_rp = m_q[0];
                for (int i = 0; i < SLOTS - 1; i++) m_q[i] = m_q[i+1];
                m_cnt--;
            end
            m_held  = full && (req || m_held);
            m_timer = cap ? 0 : (m_timer < 65535 ? m_timer + 1 : m_timer);
        end
        @(negedge clk);
        chk(restore_valid == exp_rv, tag, "restore strobe (R6)", REG_W'(restore_valid),
            REG_W'(exp_rv));
        if (exp_rv) chk(restore_data == exp_rd, tag, "restore data", restore_data, exp_rd);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        int plist [5] = '{0, 1, 2, 5, 9};
        m_rp = '0; m_cnt = 0; m_timer = 0; m_held = 0;
        for (int i = 0; i < SLOTS; i++) m_q[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(restore_valid == 1'b0, "R1", "strobe after reset", REG_W'(restore_valid), '0);
        chk(ckpt_stall == 1'b0, "R1", "stall after reset", REG_W'(ckpt_stall), '0);
        step(0, 0, 1, '0, "R1");                         // first restore gives zeros

        // R2/R4: fill ring, overflow request, held until validate
        step(1, 0, 0, 32'hA000_0001, "R2");
        step(1, 0, 0, 32'hB000_0002, "R2");
        step(1, 0, 0, 32'hC000_0003, "R2");
        step(1, 0, 0, 32'hD000_0004, "R4");              // stall, no capture
        idle(3, "R4");                                   // stall persists
        step(0, 1, 0, '0, "R5");                         // promote A, slot frees
        step(0, 0, 0, 32'hE000_0005, "R4");              // held request captures
        step(0, 0, 1, '0, "R6");                         // restore A
        step(0, 1, 0, '0, "R5");                         // nothing waiting: ignored
        step(0, 0, 1, '0, "R5");                         // still A
        step(1, 0, 0, 32'h1111_2222, "R2");
        step(1, 1, 1, 32'h3333_4444, "R7");              // error wins over both
        step(0, 1, 0, '0, "R9");                         // nothing was captured
        step(0, 0, 1, '0, "R7");                         // still A
        step(1, 0, 0, 32'h5555_6666, "R2");
        step(0, 1, 0, '0, "R5");
        step(0, 0, 1, '0, "R2");                         // restore 5555_6666

        // R3/R8 periodic snapshots
        tmr_period = 16'd3;
        idle(14, "R3");                                  // fills then stalls
        step(0, 0, 1, '0, "R8");
        idle(4, "R8");
        step(0, 1, 0, '0, "R3");
        step(0, 0, 1, '0, "R3");

        // sweep over periods with pseudo-random traffic
        lfsr = 16'hACE1;
        foreach (plist[k]) begin
            tmr_period = TW'(plist[k]);
            for (int n = 0; n < 400; n++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(lfsr[0] & lfsr[3], lfsr[1] & ~lfsr[5], lfsr[2] & lfsr[4] & lfsr[6] & lfsr[9],
                     {lfsr, ~lfsr}, "R3");
            end
            step(0, 0, 1, '0, "R6");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule